// File: doc/BRIEF.md
# Byte-Wide Boot Loader

This block brings a processor out of reset by copying a program image from a slow external byte-wide memory into its internal 24-bit program RAM. Right after reset it starts reading bytes from a fixed external base address, one location after another, holding chip select for a fixed number of wait cycles on each access and keeping only the low eight data lines.

The image starts with a six-byte header: a 24-bit word count, then a 24-bit load address, each sent least significant byte first. Every following group of three bytes, also least significant byte first, forms one 24-bit program word. These words are written to consecutive RAM addresses starting at the load address. Once the last word has been written, the loader gives a single-cycle start pulse that carries the load address as the new program counter. It then stays silent until the next reset. A word count of zero goes straight to the start pulse.

Top module: `byte_boot_loader`

## Requirements
- R1: While reset is asserted, `mem_cs`, `ram_we` and `boot_done` are 0 and `mem_addr` equals the base address (default 0xD00000).
- R2: The first read after reset uses the base address. Each later read uses the address of the previous read plus one.
- R3: For each read, `mem_cs` stays high for exactly WAIT_CYCLES consecutive cycles (default 31) and `mem_addr` does not change. `mem_cs` is low for at least one cycle between reads.
- R4: Only bits 7..0 of `mem_data` are used. The upper bits never affect a written word, the word count or the start address.
- R5: Bytes 0 to 2 form the word count and bytes 3 to 5 form the load address. In each, the first byte is bits 7..0, the second is bits 15..8 and the third is bits 23..16.
- R6: With a word count of N, exactly N RAM writes take place. Write i (counting from 0) goes to load address + i (mod 2^24), and its data is {byte 3i+8, byte 3i+7, byte 3i+6}.
- R7: A word count of zero gives no RAM write. `boot_done` rises after exactly six reads.
- R8: `boot_done` is high for exactly one cycle, with `boot_pc` equal to the load address. When N > 0, this is the cycle right after the last `ram_we` cycle.
- R9: After `boot_done`, there are no further reads, writes or start pulses until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W (24) | External byte address |
| mem_cs | output | 1 | External chip select, held for the whole wait window |
| mem_data | input | DATA_W (16) | External read data; only bits 7..0 are used |
| ram_we | output | 1 | Program RAM write strobe |
| ram_addr | output | 24 | Program RAM word address |
| ram_wdata | output | 24 | Program RAM write data |
| boot_done | output | 1 | Start pulse, one cycle long |
| boot_pc | output | 24 | Start address, valid while `boot_done` is high |

## Verification
The bench loads four images. The first is an ordinary three-word image with a load address whose three bytes all differ, so a swapped byte in the header or in a word is caught. The second has a word count of zero and shows that the loader goes straight to the start pulse. The third has a load address of 0xFFFFFE, which forces the write address to wrap. The fourth is a single all-ones word loaded at address zero, which catches stuck bits and an off-by-one in the last-word test. During every read the external model drives changing junk on the upper data lines, which shows whether they are ignored. It also measures each chip-select window, and after the start pulse it watches a quiet period.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int WORD_BYTES = 3;
    localparam int WORD_W     = 8 * WORD_BYTES;

    typedef enum logic [2:0] {
        ST_COUNT,
        ST_ADDR,
        ST_LOAD,
        ST_DONE,
        ST_HALT
    } boot_state_e;

endpackage

// File: rtl/boot_byte_fetch.sv
module boot_byte_fetch #(
    parameter int              ADDR_W      = 24,
    parameter int              DATA_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hD00000,
    parameter int              WAIT_CYCLES = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              byte_vld_o,
    output logic [7:0]        byte_o
);

    localparam int              CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    typedef struct packed {
        logic              cs;
        logic              vld;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } fetch_t;

    fetch_t fetch_d, fetch_q;

    always_comb begin
        fetch_d     = fetch_q;
        fetch_d.vld = 1'b0;
        if (fetch_q.cs) begin
            if (fetch_q.cnt == LAST) begin
                fetch_d.cs   = 1'b0;
                fetch_d.vld  = 1'b1;
                fetch_d.data = mem_data_i[7:0];
                fetch_d.addr = fetch_q.addr + 1'b1;
            end else begin
                fetch_d.cnt = fetch_q.cnt + 1'b1;
            end
        end else if (run_i && !fetch_q.vld) begin
            fetch_d.cs  = 1'b1;
            fetch_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_q <= '{cs: 1'b0, vld: 1'b0, cnt: '0, addr: BASE_ADDR, data: 8'h00};
        end else begin
            fetch_q <= fetch_d;
        end
    end

    assign mem_addr_o = fetch_q.addr;
    assign mem_cs_o   = fetch_q.cs;
    assign byte_vld_o = fetch_q.vld;
    assign byte_o     = fetch_q.data;

    // R3: address is held while the access window is open
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_q.cs && fetch_q.cnt != LAST) |=> (fetch_q.cs && $stable(fetch_q.addr)));

    // R3: the byte strobe falls in a cycle with chip select low
    a_r3_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_q.vld |-> !fetch_q.cs);

    // R2: each finished read advances the address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_q.cs) |-> (fetch_q.addr == $past(fetch_q.addr) + 1'b1));

endmodule

// File: rtl/boot_word_pack.sv
module boot_word_pack #(
    parameter int BYTES = boot_pkg::WORD_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld_i,
    input  logic [7:0]         byte_i,
    output logic               word_vld_o,
    output logic [8*BYTES-1:0] word_o
);

    localparam int HOLD_W = 8 * (BYTES - 1);
    localparam int IDX_W  = $clog2(BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [HOLD_W-1:0] hold;
    } pack_t;

    pack_t pack_d, pack_q;

    always_comb begin
        pack_d = pack_q;
        if (byte_vld_i) begin
            if (pack_q.idx == IDX_LAST) begin
                pack_d.idx = '0;
            end else begin
                pack_d.idx  = pack_q.idx + 1'b1;
                pack_d.hold = {byte_i, pack_q.hold[HOLD_W-1:8]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pack_q <= '0;
        end else begin
            pack_q <= pack_d;
        end
    end

    assign word_vld_o = byte_vld_i && (pack_q.idx == IDX_LAST);
    assign word_o     = {byte_i, pack_q.hold};

    // R5: the byte position never runs past the last lane
    a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        pack_q.idx <= IDX_LAST);

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
    import boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              run_o,
    output logic              ram_we_o,
    output logic [WORD_W-1:0] ram_addr_o,
    output logic [WORD_W-1:0] ram_wdata_o,
    output logic              done_o,
    output logic [WORD_W-1:0] pc_o
);

    typedef struct packed {
        boot_state_e       state;
        logic [WORD_W-1:0] remain;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] wptr;
        logic              we;
        logic [WORD_W-1:0] waddr;
        logic [WORD_W-1:0] wdata;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.we   = 1'b0;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_COUNT: if (word_vld_i) begin
                seq_d.remain = word_i;
                seq_d.state  = ST_ADDR;
            end
            ST_ADDR: if (word_vld_i) begin
                seq_d.base  = word_i;
                seq_d.wptr  = word_i;
                seq_d.state = (seq_q.remain == '0) ? ST_DONE : ST_LOAD;
            end
            ST_LOAD: if (word_vld_i) begin
                seq_d.we     = 1'b1;
                seq_d.waddr  = seq_q.wptr;
                seq_d.wdata  = word_i;
                seq_d.wptr   = seq_q.wptr + 1'b1;
                seq_d.remain = seq_q.remain - 1'b1;
                if (seq_q.remain == WORD_W'(1)) begin
                    seq_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                seq_d.done  = 1'b1;
                seq_d.state = ST_HALT;
            end
            default: seq_d.state = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_COUNT, remain: '0, base: '0, wptr: '0,
                       we: 1'b0, waddr: '0, wdata: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run_o       = (seq_q.state == ST_COUNT) || (seq_q.state == ST_ADDR) ||
                         (seq_q.state == ST_LOAD);
    assign ram_we_o    = seq_q.we;
    assign ram_addr_o  = seq_q.waddr;
    assign ram_wdata_o = seq_q.wdata;
    assign done_o      = seq_q.done;
    assign pc_o        = seq_q.base;

    // R8: the start pulse lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // R9: once halted, nothing more happens
    a_r9_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_HALT) |=> (seq_q.state == ST_HALT && !seq_q.we && !seq_q.done));

    // R7: a zero count goes to the handoff without writing
    a_r7_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_ADDR && word_vld_i && seq_q.remain == '0)
            |=> (seq_q.state == ST_DONE && !seq_q.we));

    // R6: writes only come out of the load phase
    a_r6_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.we |-> (seq_q.state == ST_LOAD || seq_q.state == ST_DONE));

endmodule

// File: rtl/byte_boot_loader.sv
module byte_boot_loader #(
    parameter int                ADDR_W      = 24,
    parameter int                DATA_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 24'hD00000,
    parameter int                WAIT_CYCLES = 31
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_cs,
    input  logic [DATA_W-1:0]         mem_data,
    output logic                      ram_we,
    output logic [boot_pkg::WORD_W-1:0] ram_addr,
    output logic [boot_pkg::WORD_W-1:0] ram_wdata,
    output logic                      boot_done,
    output logic [boot_pkg::WORD_W-1:0] boot_pc
);

    localparam int WW = boot_pkg::WORD_W;

    logic          run;
    logic          byte_vld;
    logic [7:0]    byte_val;
    logic          word_vld;
    logic [WW-1:0] word_val;

    boot_byte_fetch #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BASE_ADDR   (BASE_ADDR),
        .WAIT_CYCLES (WAIT_CYCLES)
    ) i_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .mem_addr_o (mem_addr),
        .mem_cs_o   (mem_cs),
        .mem_data_i (mem_data),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val)
    );

    boot_word_pack #(
        .BYTES (boot_pkg::WORD_BYTES)
    ) i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_val),
        .word_vld_o (word_vld),
        .word_o     (word_val)
    );

    boot_seq_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld_i  (word_vld),
        .word_i      (word_val),
        .run_o       (run),
        .ram_we_o    (ram_we),
        .ram_addr_o  (ram_addr),
        .ram_wdata_o (ram_wdata),
        .done_o      (boot_done),
        .pc_o        (boot_pc)
    );

    // R9: no external access is opened after the start pulse
    a_r9_no_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> !mem_cs);

endmodule

// File: tb/test_byte_boot_loader.sv
`timescale 1ns/1ps
module test_byte_boot_loader;

    localparam logic [23:0] BASE = 24'hD00000;
    localparam int          WAIT = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_cs;
    logic [15:0] mem_data;
    logic        ram_we;
    logic [23:0] ram_addr;
    logic [23:0] ram_wdata;
    logic        boot_done;
    logic [23:0] boot_pc;

    always #2 clk = ~clk;

    byte_boot_loader i_byte_boot_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_cs    (mem_cs),
        .mem_data  (mem_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .boot_done (boot_done),
        .boot_pc   (boot_pc)
    );

    // external byte memory model; upper lines carry junk
    logic [7:0] img [0:63];
    logic [7:0] junk = 8'h3C;
    always_comb begin
        if (mem_cs) mem_data = {junk, img[6'(mem_addr - BASE)]};
        else        mem_data = {junk, ~junk};
    end

    typedef struct packed { logic [23:0] a; logic [23:0] d; } wr_t;
    wr_t         exp_q[$];
    logic [23:0] exp_pc;
    int          exp_words;

    int checks = 0;
    int failures = 0;
    int cycle = 0;
    int nreads, cs_len, nwrites, last_we_cycle, post_act;
    bit done_seen, cs_prev;
    logic [23:0] addr_hold;

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: compares outputs against the scoreboard
    always @(negedge clk) begin
        wr_t e;
        cycle++;
        junk <= junk * 8'd5 + 8'd17;
        if (cycle > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycle, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (rst_n) begin
            if (mem_cs && !cs_prev) begin
                if (done_seen) post_act++;
                chk(mem_addr == BASE + 24'(nreads), "R2 read address", mem_addr, BASE + 24'(nreads));
                nreads++;
                cs_len = 1;
                addr_hold = mem_addr;
            end else if (mem_cs) begin
                cs_len++;
                if (mem_addr != addr_hold) chk(1'b0, "R3 address moved", mem_addr, addr_hold);
            end else if (cs_prev) begin
                chk(cs_len == WAIT, "R3 select length", 24'(cs_len), 24'(WAIT));
            end
            cs_prev = mem_cs;
            if (ram_we) begin
                if (done_seen) post_act++;
                nwrites++;
                last_we_cycle = cycle;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 R7 unexpected write", ram_addr, 24'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(ram_addr == e.a, "R6 write address", ram_addr, e.a);
                    chk(ram_wdata == e.d, "R6 R4 write data", ram_wdata, e.d);
                end
            end
            if (boot_done) begin
                if (done_seen) begin
                    post_act++;
                    chk(1'b0, "R8 second start pulse", 24'(cycle), 24'h0);
                end else begin
                    chk(boot_pc == exp_pc, "R8 R5 start address", boot_pc, exp_pc);
                    chk(exp_q.size() == 0, "R6 missing writes", 24'(exp_q.size()), 24'h0);
                    chk(nreads == 6 + 3 * exp_words, "R5 R7 read count", 24'(nreads), 24'(6 + 3 * exp_words));
                    if (exp_words > 0)
                        chk(cycle == last_we_cycle + 1, "R8 pulse after last write",
                            24'(cycle - last_we_cycle), 24'h1);
                    else
                        chk(nwrites == 0, "R7 no writes for zero count", 24'(nwrites), 24'h0);
                    done_seen = 1'b1;
                end
            end
        end
    end

    // driver: builds the image and pushes the expected writes
    task automatic run_image(input int n, input logic [23:0] ld, input logic [23:0] w [4]);
        logic [23:0] cnt = 24'(n);
        img[0] = cnt[7:0];  img[1] = cnt[15:8]; img[2] = cnt[23:16];
        img[3] = ld[7:0];   img[4] = ld[15:8];  img[5] = ld[23:16];
        exp_q.delete();
        for (int i = 0; i < n; i++) begin
            img[6 + 3 * i] = w[i][7:0];
            img[7 + 3 * i] = w[i][15:8];
            img[8 + 3 * i] = w[i][23:16];
            exp_q.push_back('{a: ld + 24'(i), d: w[i]});
        end
        exp_pc = ld;
        exp_words = n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_cs, "R1 select in reset", 24'(mem_cs), 24'h0);
        chk(!ram_we, "R1 write in reset", 24'(ram_we), 24'h0);
        chk(!boot_done, "R1 done in reset", 24'(boot_done), 24'h0);
        chk(mem_addr == BASE, "R1 address in reset", mem_addr, BASE);
        nreads = 0; cs_len = 0; nwrites = 0; last_we_cycle = 0; post_act = 0;
        done_seen = 1'b0; cs_prev = 1'b0;
        rst_n = 1'b1;
        while (!done_seen) @(negedge clk);
        repeat (120) @(negedge clk);
        // R9: quiet after handoff
        chk(post_act == 0, "R9 activity after done", 24'(post_act), 24'h0);
        chk(!mem_cs && !ram_we && !boot_done, "R9 outputs idle", 24'({mem_cs, ram_we, boot_done}), 24'h0);
    endtask

    initial begin
        logic [23:0] w [4];
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        w = '{24'h112233, 24'hA5B6C7, 24'h00FF10, 24'h0};
        run_image(3, 24'h3A5C71, w);
        w = '{24'hDEAD01, 24'h0, 24'h0, 24'h0};
        run_image(0, 24'h00ABCD, w);
        w = '{24'h010203, 24'h807060, 24'h5A5A5A, 24'hC3E1F0};
        run_image(4, 24'hFFFFFE, w);
        w = '{24'hFFFFFF, 24'h0, 24'h0, 24'h0};
        run_image(1, 24'h000000, w);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule